// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial bus slave that holds a small bank of 8-bit configuration registers for a clock generator. Both bus lines are oversampled by a fast system clock through two-flop synchronisers. START and STOP conditions are found as SDA edges while SCL is high. The slave acknowledges, and returns read data, by asserting a single pull-down enable that the pad drives open-drain.

Only whole-bank transfers are supported. A write names the slave with the write address byte. The master then sends a command byte and a count byte, which are acknowledged but whose values are dropped. The following data bytes land in register 0, 1, 2 and upward. A read names the slave with the read address byte. The slave first returns the number of registers, then every register from index 0 upward, MSB first. The whole bank is visible at all times on a flat parallel output bus.

Top module: `smbcfg_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low during the ninth clock) the address byte 0xD2, which opens a write, and 0xD3, which opens a read.
- R2: In a write, the two bytes that follow the address are acknowledged and their values have no effect on any register.
- R3: Write data bytes after those two are stored in register 0, then 1, and so on, and each is acknowledged. Register i appears on `cfg_bus[8*i+7:8*i]`.
- R4: A STOP after any complete data byte keeps the registers already written and leaves registers not reached unchanged.
- R5: A read returns the byte count 8 first, then registers 0 to 7 in index order, each MSB first.
- R6: Reset loads every register from the `RESET_VAL` parameter and releases SDA.
- R7: An address byte other than 0xD2 or 0xD3 is not acknowledged, and the slave leaves the bus alone until the next START.
- R8: Write data bytes beyond register 7 are acknowledged and discarded.
- R9: When the master answers a read byte with NACK, the slave releases SDA and drives nothing until STOP or a new START.
- R10: A START in the middle of a transfer returns the slave to the address phase, so a following write again begins at register 0.
- R11: The slave changes its SDA drive only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull_low | output | 1 | When high, the pad pulls SDA to ground |
| cfg_bus | output | 64 | All configuration registers, register i in bits 8*i+7 to 8*i |

## Verification
Assertions check three things on every cycle: the SDA drive only changes after a low SCL sample, the slave never drives the line while it ignores the bus, and the register bank holds still unless a write strobe lands on a valid index. The sequence behaviour can only be shown by bus scenarios. This covers which address bytes earn an acknowledge, the discarding of the command and count bytes, the index order of loaded and returned bytes, partial writes, overflow writes, NACK release and restart in mid-transfer.

// File: rtl/smbcfg_pkg.sv
`timescale 1ns/1ps
package smbcfg_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_RX,
    S_RACK,
    S_TX,
    S_MACK,
    S_IGNORE
  } slv_state_t;
endpackage

// File: rtl/smbcfg_linesync.sv
`timescale 1ns/1ps
module smbcfg_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh   <= {sda_sh[STAGES-2:0], sda_in};
      scl_prev <= scl_sh[STAGES-1];
      sda_prev <= sda_sh[STAGES-1];
    end
  end

  assign scl_lvl   = scl_sh[STAGES-1];
  assign sda_lvl   = sda_sh[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/smbcfg_regs.sv
`timescale 1ns/1ps
module smbcfg_regs #(
  parameter int NREG = 8,
  parameter int DW = 8,
  parameter int IW = 4,
  parameter logic [NREG*DW-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IW-1:0]     widx,
  input  logic [DW-1:0]     wdata,
  output logic [NREG*DW-1:0] q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        q[g*DW +: DW] <= RESET_VAL[g*DW +: DW];
      else if (we && widx == IW'(g))
        q[g*DW +: DW] <= wdata;
    end
  end

  // R6
  reset_load_chk: assert property (@(posedge clk) rst |=> (q == RESET_VAL));
  // R4
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst) !we |=> $stable(q));
  // R8
  index_range_chk: assert property (@(posedge clk) disable iff (rst) we |-> (widx < IW'(NREG)));
endmodule

// File: rtl/smbcfg_slave.sv
`timescale 1ns/1ps
module smbcfg_slave
  import smbcfg_pkg::*;
#(
  parameter int NREG = 8,
  parameter int DW = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int SYNC_STAGES = 2,
  parameter logic [NREG*DW-1:0] RESET_VAL = 64'h8877_6655_4433_2211
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_pull_low,
  output logic [NREG*DW-1:0] cfg_bus
);
  localparam int RIW = $clog2(NREG);
  localparam int TXW = $clog2(NREG + 1);
  localparam int RXW = $clog2(NREG + 2) + 1;
  localparam int BCW = $clog2(DW + 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  slv_state_t st;
  logic [BCW-1:0] bitcnt;
  logic [DW-1:0]  sh;
  logic           rd_mode, mack_ok, drv;
  logic [RXW-1:0] rx_cnt;
  logic [TXW-1:0] tx_idx;
  logic           we;
  logic [RXW-1:0] widx;
  logic [DW-1:0]  regs_a [NREG];
  logic [DW-1:0]  nxt_byte;
  logic           byte_done;

  smbcfg_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  always_comb begin
    for (int i = 0; i < NREG; i++) regs_a[i] = cfg_bus[i*DW +: DW];
    nxt_byte = regs_a[tx_idx[RIW-1:0]];
  end

  assign byte_done = scl_fall && (bitcnt == BCW'(DW));
  assign we   = (st == S_RX) && byte_done && !start_det && !stop_det
                && (rx_cnt >= RXW'(2)) && (rx_cnt < RXW'(NREG + 2));
  assign widx = rx_cnt - RXW'(2);

  smbcfg_regs #(.NREG(NREG), .DW(DW), .IW(RXW), .RESET_VAL(RESET_VAL)) u_regs (
    .clk(clk), .rst(rst), .we(we), .widx(widx), .wdata(sh), .q(cfg_bus)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      drv     <= 1'b0;
      bitcnt  <= '0;
      sh      <= '0;
      rd_mode <= 1'b0;
      mack_ok <= 1'b0;
      rx_cnt  <= '0;
      tx_idx  <= '0;
    end else if (start_det) begin
      st     <= S_ADDR;
      bitcnt <= '0;
      drv    <= 1'b0;
    end else if (stop_det) begin
      st  <= S_IDLE;
      drv <= 1'b0;
    end else begin
      case (st)
        S_ADDR: begin
          if (scl_rise) begin
            sh     <= {sh[DW-2:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            if (sh[DW-1:1] == DEV_ADDR) begin
              drv     <= 1'b1;
              rd_mode <= sh[0];
              rx_cnt  <= '0;
              tx_idx  <= '0;
              st      <= S_AACK;
            end else begin
              st <= S_IGNORE;
            end
          end
        end
        S_AACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode) begin
              sh  <= DW'(NREG);
              drv <= ~DW'(NREG) >> (DW - 1);
              st  <= S_TX;
            end else begin
              drv <= 1'b0;
              st  <= S_RX;
            end
          end
        end
        S_RX: begin
          if (scl_rise) begin
            sh     <= {sh[DW-2:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end else if (byte_done) begin
            drv <= 1'b1;
            st  <= S_RACK;
            if (rx_cnt < RXW'(NREG + 2)) rx_cnt <= rx_cnt + 1'b1;
          end
        end
        S_RACK: begin
          if (scl_fall) begin
            drv    <= 1'b0;
            bitcnt <= '0;
            st     <= S_RX;
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 1'b1;
          end else if (scl_fall) begin
            if (bitcnt == BCW'(DW)) begin
              drv <= 1'b0;
              st  <= S_MACK;
            end else begin
              sh  <= {sh[DW-2:0], 1'b0};
              drv <= ~sh[DW-2];
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            mack_ok <= ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_ok && tx_idx < TXW'(NREG)) begin
              sh     <= nxt_byte;
              drv    <= ~nxt_byte[DW-1];
              tx_idx <= tx_idx + 1'b1;
              bitcnt <= '0;
              st     <= S_TX;
            end else begin
              st <= S_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_low = drv;

  // R11
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    (drv != $past(drv)) |-> !$past(scl_lvl));
  // R7
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IGNORE) |-> !sda_pull_low);
  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_MACK && $past(st) == S_MACK) |-> !sda_pull_low);
endmodule

// File: tb/smbcfg_slave_test.sv
`timescale 1ns/1ps
module smbcfg_slave_test;
  localparam logic [63:0] DEFV = 64'hA1B2_C3D4_E5F6_0718;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic pull_low;
  logic [63:0] cfg_bus;
  logic sda_line;
  assign sda_line = m_sda & ~pull_low;

  always #10 clk = ~clk;

  smbcfg_slave #(.RESET_VAL(DEFV)) uut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .sda_pull_low(pull_low), .cfg_bus(cfg_bus)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] model [8];

  int    exp_val [$];
  string exp_tag [$];
  int    obs_val;
  event  obs_ev;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(obs_ev);
      if (exp_val.size() == 0) begin
        check("scoreboard-empty", obs_val, -1);
      end else begin
        check(exp_tag.pop_front(), obs_val, exp_val.pop_front());
      end
    end
  end

  task automatic expect_item(input string tag, input int v);
    exp_val.push_back(v);
    exp_tag.push_back(tag);
  endtask

  task automatic observe(input int v);
    obs_val = v;
    ->obs_ev;
    @(negedge clk);
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    wq(); m_sda = b;
    wq(); scl = 1'b1;
    wq(); s = sda_line;
    wq(); scl = 1'b0;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq();
    scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq();
    scl = 1'b1; wq();
    m_sda = 1'b1; wq();
    wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag, input bit exp_ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    expect_item(tag, exp_ack ? 1 : 0);
    observe(s == 1'b0 ? 1 : 0);
  endtask

  task automatic recv_byte(input bit give_ack, input string tag, input int exp_b);
    logic s;
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      b[i] = s;
    end
    bit_io(give_ack ? 1'b0 : 1'b1, s);
    expect_item(tag, exp_b);
    observe(int'(b));
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < 8; i++) check(tag, cfg_bus[i*8 +: 8], model[i]);
  endtask

  task automatic block_write(input int n, input int seed, input logic [7:0] cmd, input logic [7:0] cnt);
    bus_start();
    send_byte(8'hD2, "R1 write address ack", 1);
    send_byte(cmd, "R2 command ack", 1);
    send_byte(cnt, "R2 count ack", 1);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(i * 37 + seed);
      send_byte(d, i < 8 ? "R3 data ack" : "R8 overflow ack", 1);
      if (i < 8) model[i] = d;
    end
    bus_stop();
  endtask

  task automatic block_read(input int nack_at);
    bus_start();
    send_byte(8'hD3, "R1 read address ack", 1);
    recv_byte(1, "R5 byte count", 8);
    for (int i = 0; i < 8; i++) begin
      bit ack;
      ack = (i < 7) && (i != nack_at);
      if (i <= nack_at) recv_byte(ack, "R5 read data", int'(model[i]));
      else recv_byte(ack, "R9 released after NACK", 8'hFF);
    end
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = DEFV[i*8 +: 8];
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    check_bank("R6 reset defaults");
    check("R6 SDA released", pull_low, 0);

    block_read(8);

    block_write(8, 3, 8'h00, 8'h05);
    check_bank("R3 full write, R2 command/count ignored");
    block_read(8);

    block_write(3, 91, 8'hFF, 8'hFF);
    check_bank("R4 partial write");
    block_read(8);

    bus_start();
    send_byte(8'hA0, "R7 foreign address nack", 0);
    send_byte(8'h5A, "R7 ignored byte nack", 0);
    bus_stop();
    check_bank("R7 bank untouched");
    check("R7 SDA released", pull_low, 0);

    block_write(10, 200, 8'h44, 8'h08);
    check_bank("R8 overflow write");

    block_read(2);
    check("R9 SDA released after stop", pull_low, 0);

    bus_start();
    send_byte(8'hD2, "R10 first address ack", 1);
    send_byte(8'h01, "R10 command ack", 1);
    send_byte(8'h02, "R10 count ack", 1);
    send_byte(8'h3C, "R10 first data ack", 1);
    model[0] = 8'h3C;
    bus_start();
    send_byte(8'hD2, "R10 restart address ack", 1);
    send_byte(8'h77, "R10 restart command ack", 1);
    send_byte(8'h66, "R10 restart count ack", 1);
    send_byte(8'hC9, "R10 restart data ack", 1);
    model[0] = 8'hC9;
    bus_stop();
    check_bank("R10 restart writes register 0");
    block_read(8);

    check("scoreboard drained", exp_val.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule